// File: doc/BRIEF.md
# Sleep Interval Wake-Up Timer with Receive Duty Cycling

This block measures sleep intervals for a low-power radio. Software writes an 8-bit mantissa and a 5-bit exponent; the interval length is the mantissa shifted left by the exponent, in millisecond units, plus a fixed half-unit offset. A prescaled tick input, one pulse per half unit, replaces the slow on-chip RC clock. When the interval has elapsed, the block sets a wake-up flag. The flag stays set until software reads the status.

Each interval runs once. A rising edge on the enable input arms the timer and captures the configuration. Once the interval has expired, the timer stays idle until enable is dropped and raised again. Enable low stops and clears the interval in progress.

In the optional duty-cycle mode, a receiver-enable output is driven high at the start of each armed interval. It stays high for an on-time of (2·D+1) units scaled by the same exponent, where D is a 7-bit duty field. Since the period is mantissa units scaled the same way, the on-time is the fraction (2·D+1)/mantissa of the interval. The output is then held low for the rest of the interval.

Top module: `wake_duty_timer`

## Requirements
- R1: After reset, wakeIrq and rxEn are both 0.
- R2: After arming with mantissa M > 0 and exponent E, wakeIrq rises on the tick that completes P = 2·(M·2^E) + OFFSET_TICKS ticks (OFFSET_TICKS defaults to 1). The flag is visible in the cycle after that tick is sampled, and not earlier.
- R3: Mantissa, exponent, duty field and duty mode are captured on the rising edge of enable. Changes made while an interval runs do not affect it.
- R4: After an expiry, further ticks start no new interval while enable stays high. A new interval needs enable to go low and then high again.
- R5: Enable low stops the interval and forces rxEn low. The next rising edge starts a fresh, full interval from zero.
- R6: A cycle with statusRead high clears wakeIrq. If statusRead coincides with the expiring tick, the flag is set.
- R7: With a mantissa of 0 the interval never expires.
- R8: With duty mode set, rxEn is 1 while the timer is armed and the number of elapsed ticks k satisfies k < 2·((2·D+1)·2^E). It is 0 otherwise and after expiry. With duty mode clear, rxEn stays 0.
- R9: If the on-time is at least the period, rxEn stays high for the whole interval until it expires.
- R10: Ticks that arrive while the timer is not armed, or in the cycle it arms, do not advance the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled half-unit tick pulse, one cycle wide |
| enable | input | 1 | Timer enable; a rising edge arms one interval |
| dutyMode | input | 1 | Selects duty-cycled receiver enable |
| mantissa | input | MANT_W | Interval mantissa |
| exponent | input | EXP_W | Interval exponent (power-of-two scale) |
| dutyField | input | DC_W | Duty field D giving on-time 2·D+1 units |
| statusRead | input | 1 | Status read strobe; clears the wake flag |
| wakeIrq | output | 1 | Wake-up interrupt status flag |
| rxEn | output | 1 | Receiver enable in duty-cycle mode |

## Verification
The assertions check several properties on every cycle. The elapsed count never passes the latched period. Arming zeroes the count. The run state only starts after an enable edge. Dropping enable leaves the timer idle with rxEn low. The flag responds correctly to an expiry and to a status read. The exact tick on which the flag rises, and the tick on which rxEn falls, come from the arithmetic on mantissa, exponent and duty field. Only the bench's sweeps over many configurations can show those, along with the re-arm rule, the capture of configuration at arming, and the zero-mantissa case.

// File: rtl/wake_duty_timer_pkg.sv
package wake_duty_timer_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic arm;    // capture configuration, zero the count
    logic clear;  // hold the count at zero
    logic step;   // advance the elapsed count by one tick
  } wutStrobe_t;
endpackage

// File: rtl/wake_duty_ctrl.sv
module wake_duty_ctrl
  import wake_duty_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic       statusRead,
  input  logic       lastStep,
  input  logic       rxWindow,
  output wutStrobe_t strobe,
  output logic       wakeIrq,
  output logic       rxEn
);
  logic enableQ;
  logic running;
  logic armEdge;
  logic expire;

  assign armEdge      = enable && !enableQ;
  assign expire       = running && tick && lastStep && !armEdge;
  assign strobe.arm   = armEdge;
  assign strobe.clear = !enable;
  assign strobe.step  = running && tick && !armEdge;
  assign rxEn         = running && rxWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      running <= 1'b0;
      wakeIrq <= 1'b0;
    end else begin
      enableQ <= enable;
      if (!enable)      running <= 1'b0;
      else if (armEdge) running <= 1'b1;
      else if (expire)  running <= 1'b0;
      if (expire)          wakeIrq <= 1'b1;
      else if (statusRead) wakeIrq <= 1'b0;
    end
  end

  // R4
  arm_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(enable) && !$past(enableQ));
  // R5
  disarm_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !running && !rxEn);
  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusRead && !expire |=> !wakeIrq);
  // R2
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> wakeIrq && !running);
endmodule

// File: rtl/wake_duty_dpath.sv
module wake_duty_dpath
  import wake_duty_timer_pkg::*;
#(
  parameter int MANT_W       = 8,
  parameter int EXP_W        = 5,
  parameter int DC_W         = 7,
  parameter int OFFSET_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wutStrobe_t        strobe,
  input  logic              dutyMode,
  input  logic [MANT_W-1:0] mantissa,
  input  logic [EXP_W-1:0]  exponent,
  input  logic [DC_W-1:0]   dutyField,
  output logic              lastStep,
  output logic              rxWindow
);
  localparam int SHIFT_MAX = (1 << EXP_W) - 1;
  localparam int CNT_W     = MANT_W + SHIFT_MAX + 2;

  logic [MANT_W-1:0] mantQ;
  logic [EXP_W-1:0]  expQ;
  logic [DC_W-1:0]   dcQ;
  logic              dutyQ;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  periodTicks;
  logic [CNT_W-1:0]  onTicks;
  logic              mantNz;

  assign mantNz      = |mantQ;
  assign periodTicks = ((CNT_W'(mantQ) << expQ) << 1) + CNT_W'(OFFSET_TICKS);
  assign onTicks     = (CNT_W'({dcQ, 1'b1}) << expQ) << 1;
  assign lastStep    = mantNz && ((count + CNT_W'(1)) == periodTicks);
  assign rxWindow    = dutyQ && (count < onTicks);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mantQ <= '0;
      expQ  <= '0;
      dcQ   <= '0;
      dutyQ <= 1'b0;
      count <= '0;
    end else begin
      if (strobe.arm) begin
        mantQ <= mantissa;
        expQ  <= exponent;
        dcQ   <= dutyField;
        dutyQ <= dutyMode;
      end
      if (strobe.arm || strobe.clear) count <= '0;
      else if (strobe.step)           count <= count + CNT_W'(1);
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    mantNz |-> count <= periodTicks);
  // R3
  arm_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arm |=> count == '0);
  // R10
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step && !strobe.arm && !strobe.clear |=> $stable(count));
endmodule

// File: rtl/wake_duty_timer.sv
module wake_duty_timer
  import wake_duty_timer_pkg::*;
#(
  parameter int MANT_W       = 8,
  parameter int EXP_W        = 5,
  parameter int DC_W         = 7,
  parameter int OFFSET_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              enable,
  input  logic              dutyMode,
  input  logic [MANT_W-1:0] mantissa,
  input  logic [EXP_W-1:0]  exponent,
  input  logic [DC_W-1:0]   dutyField,
  input  logic              statusRead,
  output logic              wakeIrq,
  output logic              rxEn
);
  wutStrobe_t strobe;
  logic       lastStep;
  logic       rxWindow;

  wake_duty_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .statusRead(statusRead), .lastStep(lastStep), .rxWindow(rxWindow),
    .strobe(strobe), .wakeIrq(wakeIrq), .rxEn(rxEn)
  );

  wake_duty_dpath #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .DC_W(DC_W), .OFFSET_TICKS(OFFSET_TICKS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dutyMode(dutyMode),
    .mantissa(mantissa), .exponent(exponent), .dutyField(dutyField),
    .lastStep(lastStep), .rxWindow(rxWindow)
  );
endmodule

// File: tb/wake_duty_timer_tb.sv
module wake_duty_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       enable = 1'b0;
  logic       dutyMode = 1'b0;
  logic [7:0] mantissa = '0;
  logic [4:0] exponent = '0;
  logic [6:0] dutyField = '0;
  logic       statusRead = 1'b0;
  logic       wakeIrq;
  logic       rxEn;
  int         nChecks = 0;
  int         nFails = 0;
  int         cycles = 0;

  always #2.5 clk = ~clk;

  wake_duty_timer u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .dutyMode(dutyMode),
    .mantissa(mantissa), .exponent(exponent), .dutyField(dutyField),
    .statusRead(statusRead), .wakeIrq(wakeIrq), .rxEn(rxEn)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic clearFlag();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic doArm(input int m, input int e, input int dc, input logic dm);
    enable = 1'b0;
    clearFlag();
    mantissa = 8'(m); exponent = 5'(e); dutyField = 7'(dc); dutyMode = dm;
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  function automatic int periodOf(input int m, input int e);
    return 2 * (m << e) + 1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", wakeIrq, 1'b0);
    check("R1 rxEn", rxEn, 1'b0);

    // R2 R8 R9 sweep over small configurations
    for (int m = 1; m <= 5; m++)
      for (int e = 0; e <= 2; e++)
        for (int dc = 0; dc <= 3; dc++) begin
          int p;
          int on;
          p  = periodOf(m, e);
          on = 2 * ((2 * dc + 1) << e);
          doArm(m, e, dc, 1'b1);
          for (int k = 0; k <= p; k++) begin
            if (k > 0) tickN(1);
            check("R2 irq", wakeIrq, k >= p);
            if (on >= p) check("R9 rxEn", rxEn, k < p);
            else         check("R8 rxEn", rxEn, k < p && k < on);
          end
        end

    // R8 duty mode off keeps rxEn low
    doArm(3, 1, 5, 1'b0);
    for (int k = 0; k <= 13; k++) begin
      if (k > 0) tickN(1);
      check("R8 off rxEn", rxEn, 1'b0);
      check("R2 off irq", wakeIrq, k >= 13);
    end

    // R3 configuration changes mid-interval have no effect (P = 5)
    doArm(2, 0, 0, 1'b1);
    tickN(1);
    mantissa = 8'd7; exponent = 5'd2; dutyField = 7'd9; dutyMode = 1'b0;
    tickN(1);
    check("R3 rxEn duty kept", rxEn, 1'b0);
    tickN(2);
    check("R3 irq early", wakeIrq, 1'b0);
    tickN(1);
    check("R3 irq at latched period", wakeIrq, 1'b1);

    // R4 no new interval without re-arm
    clearFlag();
    check("R6 status clear", wakeIrq, 1'b0);
    tickN(60);
    check("R4 no restart", wakeIrq, 1'b0);
    check("R4 rxEn idle", rxEn, 1'b0);
    doArm(1, 0, 0, 1'b1);
    tickN(2);
    check("R4 rearm early", wakeIrq, 1'b0);
    tickN(1);
    check("R4 rearm expiry", wakeIrq, 1'b1);

    // R5 R10 enable low aborts, ticks ignored while disarmed (P = 7)
    doArm(3, 0, 3, 1'b1);
    tickN(4);
    check("R5 rxEn armed", rxEn, 1'b1);
    enable = 1'b0;
    @(negedge clk);
    check("R5 rxEn disarmed", rxEn, 1'b0);
    tickN(5);
    check("R10 ignored ticks", wakeIrq, 1'b0);
    tick = 1'b1; enable = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    tickN(6);
    check("R10 arm-cycle tick ignored", wakeIrq, 1'b0);
    check("R5 fresh interval rxEn", rxEn, 1'b1);
    tickN(1);
    check("R5 fresh interval expiry", wakeIrq, 1'b1);

    // R6 set wins over a coincident status read (P = 3)
    doArm(1, 0, 0, 1'b0);
    tickN(2);
    tick = 1'b1; statusRead = 1'b1;
    @(negedge clk);
    tick = 1'b0; statusRead = 1'b0;
    check("R6 set wins", wakeIrq, 1'b1);
    clearFlag();
    check("R6 read clears", wakeIrq, 1'b0);

    // R7 zero mantissa never expires
    doArm(0, 3, 0, 1'b0);
    tickN(300);
    check("R7 zero mantissa", wakeIrq, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule